// File: doc/BRIEF.md
# Complementary PWM Pair with Programmable Dead Time

This block drives the high-side and low-side switches of a half bridge from one 12-bit auto-reload timer. A free-running up-counter advances once per counter tick (an enable pulse from a prescaler outside the block). When it passes its top value it restarts from a programmable reload value, so the period is `4096 - reload` ticks. A duty value sets where, inside the period, the primary output drops.

The complementary output normally mirrors the primary one. With the gap feature enabled and a non-zero gap length, both switch edges are separated. The complementary output rises a programmed number of ticks after the primary one falls. At the restart point the complementary output stays high for the same number of ticks, and the primary output is held low until the complementary one has dropped. Reload, duty and gap settings come in through a small synchronous write port. They are parked in pending registers and copied into the active set only at the counter restart, so a running period is never reshaped. Output inversion is a final per-pin XOR and takes effect at once.

Top module: `dtpwm_pair`

## Requirements
- R1: The counter leaves reset at 0, advances by one on every cycle with `tick_i` high, holds when `tick_i` is low, and on a tick at 0xFFF loads the active reload value.
- R2: A write to address 0 sets the reload value (data bits 11:0), address 1 the duty value (bits 11:0) and address 2 the gap setting (bit 7 enable, bits 6:0 length). These three take effect only on the tick at which the counter restarts. Until then, outputs behave as with the old values.
- R3: With the gap disabled, the primary output (before inversion) is high while the counter is below the duty value and low otherwise. The complementary output is its inverse.
- R4: With the gap enabled and a length L of 1 to 127, the primary output falls on the tick where the counter reaches the duty value. The complementary output rises L ticks later, and both are low in between.
- R5: With the gap enabled and L non-zero, the complementary output falls L ticks after the tick on which the counter first goes below the duty value (the restart). The primary output rises on that same tick. Without inversion, the two outputs are never high together.
- R6: If the counter goes below the duty value again while the complementary output is still waiting to rise, the primary output goes high on that tick and the complementary output does not rise.
- R7: With the gap enabled and length 0, both outputs sit at their inactive level, which is 0 before inversion.
- R8: Address 3 sets inversion at once: bit 0 inverts the primary pin, bit 1 the complementary pin. With inversion set, overlap is allowed.
- R9: Synchronous reset clears all registers and drives both pins low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Counter tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 reload, 1 duty, 2 gap, 3 inversion) |
| wr_data_i | input | 12 | Write data |
| pwm_pri_o | output | 1 | Primary (high-side) output |
| pwm_cmp_o | output | 1 | Complementary (low-side) output |

## Verification
On every cycle, the assertions check the restart load and the counter hold between ticks. They also check that the active settings do not move outside the restart tick. Further properties cover the forced-low state for a zero gap length, the complementary output staying low while its gap is counting, and non-overlap of the pins whenever the gap is active without inversion. The exact gap lengths, the short-low-phase case and the deferred effect of writes made mid-period are shown by the bench's scenarios. There, a behavioural model predicts both pins every cycle under varying tick rates, duty values, gap lengths and inversion settings.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
    typedef enum logic [1:0] {
        GS_PRI      = 2'd0,
        GS_GAP_RISE = 2'd1,
        GS_CMP      = 2'd2,
        GS_GAP_FALL = 2'd3
    } gap_state_e;

    localparam logic [1:0] ADDR_RELOAD = 2'd0;
    localparam logic [1:0] ADDR_DUTY   = 2'd1;
    localparam logic [1:0] ADDR_GAP    = 2'd2;
    localparam logic [1:0] ADDR_POL    = 2'd3;
endpackage

// File: rtl/pwm_dt_regs.sv
module pwm_dt_regs #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             ovf_i,
    output logic [CNT_W-1:0] reload_pend_o,
    output logic [CNT_W-1:0] duty_eff_o,
    output logic             gap_en_eff_o,
    output logic [DT_W-1:0]  gap_len_eff_o,
    output logic             gap_en_act_o,
    output logic [DT_W-1:0]  gap_len_act_o,
    output logic [1:0]       pol_o
);
    import pwm_dt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] rl_p;
        logic [CNT_W-1:0] du_p;
        logic [CNT_W-1:0] du_a;
        logic             gen_p;
        logic             gen_a;
        logic [DT_W-1:0]  glen_p;
        logic [DT_W-1:0]  glen_a;
        logic [1:0]       pol;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (ovf_i) begin
            regs_d.du_a   = regs_q.du_p;
            regs_d.gen_a  = regs_q.gen_p;
            regs_d.glen_a = regs_q.glen_p;
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_RELOAD: regs_d.rl_p = wr_data_i;
                ADDR_DUTY:   regs_d.du_p = wr_data_i;
                ADDR_GAP: begin
                    regs_d.gen_p  = wr_data_i[DT_W];
                    regs_d.glen_p = wr_data_i[DT_W-1:0];
                end
                default:     regs_d.pol = wr_data_i[1:0];
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) regs_q <= '0;
        else       regs_q <= regs_d;
    end

    assign reload_pend_o = regs_q.rl_p;
    assign duty_eff_o    = ovf_i ? regs_q.du_p   : regs_q.du_a;
    assign gap_en_eff_o  = ovf_i ? regs_q.gen_p  : regs_q.gen_a;
    assign gap_len_eff_o = ovf_i ? regs_q.glen_p : regs_q.glen_a;
    assign gap_en_act_o  = regs_q.gen_a;
    assign gap_len_act_o = regs_q.glen_a;
    assign pol_o         = regs_q.pol;

    // R2: active settings only move at the restart tick
    a_r2_shadow_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !ovf_i |=> ($stable(regs_q.du_a) && $stable(regs_q.gen_a) && $stable(regs_q.glen_a)));
endmodule

// File: rtl/pwm_dt_counter.sv
module pwm_dt_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             ovf_o,
    output logic             ref_nx_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign ovf_o = tick_i && (cnt_q == CNT_TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (ovf_o)       cnt_d = reload_i;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    assign ref_nx_o = (cnt_d < duty_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    // R1: restart loads the reload value
    a_r1_reload: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_o |=> (cnt_q == $past(reload_i)));
    // R1: no tick, no movement
    a_r1_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_dt_gap.sv
module pwm_dt_gap #(
    parameter int DT_W = 7
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            tick_i,
    input  logic            ref_nx_i,
    input  logic            gap_en_i,
    input  logic [DT_W-1:0] gap_len_i,
    output logic            raw_pri_o,
    output logic            raw_cmp_o
);
    import pwm_dt_pkg::*;

    typedef struct packed {
        gap_state_e      st;
        logic [DT_W-1:0] dly;
    } gap_t;

    gap_t gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (!gap_en_i) begin
            gap_d.st  = ref_nx_i ? GS_PRI : GS_CMP;
            gap_d.dly = '0;
        end else if (gap_len_i == '0) begin
            gap_d.st  = GS_GAP_RISE;
            gap_d.dly = '0;
        end else if (tick_i) begin
            case (gap_q.st)
                GS_PRI: if (!ref_nx_i) begin
                    gap_d.st  = GS_GAP_RISE;
                    gap_d.dly = gap_len_i;
                end
                GS_GAP_RISE: begin
                    if (ref_nx_i)            gap_d.st  = GS_PRI;
                    else if (gap_q.dly <= 1) gap_d.st  = GS_CMP;
                    else                     gap_d.dly = gap_q.dly - 1'b1;
                end
                GS_CMP: if (ref_nx_i) begin
                    gap_d.st  = GS_GAP_FALL;
                    gap_d.dly = gap_len_i;
                end
                default: begin
                    if (gap_q.dly <= 1) gap_d.st  = GS_PRI;
                    else                gap_d.dly = gap_q.dly - 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q.st  <= GS_GAP_RISE;
            gap_q.dly <= '0;
        end else begin
            gap_q <= gap_d;
        end
    end

    assign raw_pri_o = (gap_q.st == GS_PRI);
    assign raw_cmp_o = (gap_q.st == GS_CMP) || (gap_q.st == GS_GAP_FALL);

    // R7: zero gap length parks both outputs inactive
    a_r7_forced_low: assert property (@(posedge clk_i) disable iff (rst_i)
        (gap_en_i && gap_len_i == '0) |=> (!raw_pri_o && !raw_cmp_o));
    // R4: complementary output stays low while its gap is still counting
    a_r4_gap_wait: assert property (@(posedge clk_i) disable iff (rst_i)
        (gap_en_i && gap_len_i != '0 && tick_i && !ref_nx_i &&
         gap_q.st == GS_GAP_RISE && gap_q.dly > 1) |=> !raw_cmp_o);
endmodule

// File: rtl/dtpwm_pair.sv
module dtpwm_pair #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             pwm_pri_o,
    output logic             pwm_cmp_o
);
    logic             ovf, ref_nx, gap_en_eff, gap_en_act, raw_pri, raw_cmp;
    logic [CNT_W-1:0] reload_pend, duty_eff;
    logic [DT_W-1:0]  gap_len_eff, gap_len_act;
    logic [1:0]       pol;

    pwm_dt_regs #(.CNT_W(CNT_W), .DT_W(DT_W)) i_regs (
        .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .ovf_i(ovf), .reload_pend_o(reload_pend),
        .duty_eff_o(duty_eff), .gap_en_eff_o(gap_en_eff), .gap_len_eff_o(gap_len_eff),
        .gap_en_act_o(gap_en_act), .gap_len_act_o(gap_len_act), .pol_o(pol)
    );

    pwm_dt_counter #(.CNT_W(CNT_W)) i_counter (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .reload_i(reload_pend),
        .duty_i(duty_eff), .ovf_o(ovf), .ref_nx_o(ref_nx)
    );

    pwm_dt_gap #(.DT_W(DT_W)) i_gap (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .ref_nx_i(ref_nx),
        .gap_en_i(gap_en_eff), .gap_len_i(gap_len_eff),
        .raw_pri_o(raw_pri), .raw_cmp_o(raw_cmp)
    );

    assign pwm_pri_o = raw_pri ^ pol[0];
    assign pwm_cmp_o = raw_cmp ^ pol[1];

    // R5: active gap without inversion never lets both pins be high
    a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (rst_i)
        (gap_en_act && gap_len_act != '0 && pol == 2'b00) |-> !(pwm_pri_o && pwm_cmp_o));
endmodule

// File: tb/test_dtpwm_pair.sv
`timescale 1ns/1ps
module test_dtpwm_pair;
    logic        clk = 1'b0;
    logic        rst, tick, wr_en;
    logic [1:0]  wr_addr;
    logic [11:0] wr_data;
    logic        pri, cmp;

    always #4 clk = ~clk;

    dtpwm_pair i_dtpwm_pair (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_pri_o(pri), .pwm_cmp_o(cmp)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R9";
    bit    done = 0;

    // behavioural reference
    int m_cnt, m_rl_p, m_du_p, m_du_a, m_len_p, m_len_a, m_wait, m_pend;
    bit m_en_p, m_en_a, m_pri, m_cmp, m_ref;
    bit [1:0] m_pol;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_rl_p = 0; m_du_p = 0; m_du_a = 0; m_len_p = 0; m_len_a = 0;
            m_en_p = 0; m_en_a = 0; m_pol = 0; m_pri = 0; m_cmp = 0; m_pend = 1; m_wait = 0;
        end else begin
            if (tick) begin
                if (m_cnt == 4095) begin
                    m_du_a = m_du_p; m_en_a = m_en_p; m_len_a = m_len_p; m_cnt = m_rl_p;
                end else m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_rl_p = int'(wr_data);
                    2'd1: m_du_p = int'(wr_data);
                    2'd2: begin m_en_p = wr_data[7]; m_len_p = int'(wr_data[6:0]); end
                    default: m_pol = wr_data[1:0];
                endcase
            end
            m_ref = (m_cnt < m_du_a);
            if (!m_en_a) begin
                m_pri = m_ref; m_cmp = !m_ref; m_pend = 0;
            end else if (m_len_a == 0) begin
                m_pri = 0; m_cmp = 0; m_pend = 1; m_wait = 0;
            end else if (tick) begin
                if (m_pend == 1) begin
                    if (m_ref) begin m_pri = 1; m_pend = 0; end
                    else if (m_wait <= 1) begin m_cmp = 1; m_pend = 0; end
                    else m_wait = m_wait - 1;
                end else if (m_pend == 2) begin
                    if (m_wait <= 1) begin m_cmp = 0; m_pri = 1; m_pend = 0; end
                    else m_wait = m_wait - 1;
                end else if (m_pri && !m_ref) begin
                    m_pri = 0; m_pend = 1; m_wait = m_len_a;
                end else if (m_cmp && m_ref) begin
                    m_pend = 2; m_wait = m_len_a;
                end
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, pri, m_pri ^ m_pol[0], "primary pin");
            check(cur_req, cmp, m_cmp ^ m_pol[1], "complementary pin");
            if (m_en_a && m_len_a != 0 && m_pol == 2'b00)
                check("R5", pri & cmp, 1'b0, "overlap");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input int div);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (i % div == 0);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R9", pri, 1'b0, "primary in reset");
        check("R9", cmp, 1'b0, "complementary in reset");
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        wr(2'd0, 12'hFF0);
        wr(2'd1, 12'hFF8);
        run(4200, 1);
        cur_req = "R3";
        run(300, 3);

        cur_req = "R2";
        wr(2'd2, 12'h083);
        run(6, 1);
        wr(2'd1, 12'hFF4);
        run(8, 1);
        cur_req = "R4";
        run(200, 1);
        cur_req = "R5";
        wr(2'd2, 12'h086);
        run(300, 2);

        cur_req = "R6";
        wr(2'd1, 12'hFFE);
        wr(2'd2, 12'h085);
        run(400, 1);

        cur_req = "R7";
        wr(2'd1, 12'hFF6);
        wr(2'd2, 12'h080);
        run(100, 1);

        cur_req = "R8";
        wr(2'd2, 12'h082);
        wr(2'd3, 12'h003);
        run(120, 1);
        wr(2'd3, 12'h001);
        run(120, 2);
        wr(2'd2, 12'h000);
        run(80, 1);

        cur_req = "R1";
        wr(2'd3, 12'h000);
        wr(2'd0, 12'hFE0);
        run(200, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule